// File: doc/BRIEF.md
# Compressed Instruction Length Decoder and Expander

This block sits in the decode stage of a small processor that accepts 16-bit compressed instructions mixed with 32-bit base instructions. Each cycle it can take one 32-bit fetch word, aligned so that the instruction starts at bit 0. It looks at the two lowest bits to decide whether the instruction is 16 or 32 bits long. The length tells the fetch logic how far to advance.

A 32-bit instruction is passed through unchanged. A 16-bit instruction is rewritten into the equivalent 32-bit base instruction, so that the rest of the pipeline only ever decodes one format. Three compressed forms are supported:
- add-immediate
- load-word relative to the stack pointer
- the register-to-register logic/subtract group, which uses 3-bit register fields

Every other 16-bit pattern, and every reserved pattern of the supported forms, raises an illegal flag and yields an all-zero expansion. When the input is 16 bits long, the upper half of the fetch word is ignored.

The result is registered once: outputs appear one clock after a valid input and hold their value while no input is valid.

Top module: `cexp_decoder`

## Requirements
- R1: One cycle after a valid input, `outLen16` is 0 when `fetchWord[1:0]` is 2'b11 and 1 for 2'b00, 2'b01 or 2'b10.
- R2: A 32-bit input (low bits 2'b11) appears unchanged on `outInstr` one cycle later, with `outIllegal` low.
- R3: The compressed add-immediate form expands to `addi rd, rd, imm` (opcode 0010011, funct3 000), with rd taken from bits 11:7. This form has low bits 01 and bits 15:13 = 000. The immediate is imm[5] = bit 12 and imm[4:0] = bits 6:2, sign-extended to 12 bits.
- R4: A compressed add-immediate with rd = 0 or with a zero immediate is reserved. It sets `outIllegal` and gives `outInstr` = 0.
- R5: The stack load form expands to `lw rd, off(x2)` (opcode 0000011, funct3 010), with rd taken from bits 11:7. This form has low bits 10 and bits 15:13 = 010. The offset is zero-extended and always a multiple of 4. Its bits come from the instruction as follows: off[5] from bit 12, off[4:2] from bits 6:4, and off[7:6] from bits 3:2.
- R6: The stack load with rd = 0 is reserved. It sets `outIllegal` and gives `outInstr` = 0.
- R7: The arithmetic form expands to a register-register base instruction (opcode 0110011). This form has low bits 01 and bits 15:10 = 100011. Destination and first source are both taken from bits 9:7, and the second source from bits 4:2. A 3-bit register field value n names register x(8+n). Bits 6:5 select the operation:
  - 00: sub (funct7 0100000, funct3 000)
  - 01: xor (funct3 100)
  - 10: or (funct3 110)
  - 11: and (funct3 111)
  
  The last three use funct7 0000000.
- R8: Every other 16-bit encoding sets `outIllegal` and gives `outInstr` = 0. This includes the arithmetic group with bit 12 set and all encodings with low bits 00.
- R9: `outValid` equals `inValid` delayed by one clock. While `inValid` is low, `outLen16`, `outInstr` and `outIllegal` keep their previous values.
- R10: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Fetch word is present this cycle |
| fetchWord | input | 32 | Instruction bits, instruction starting at bit 0 |
| outValid | output | 1 | Registered result is valid |
| outLen16 | output | 1 | 1 when the instruction is 16 bits long |
| outInstr | output | 32 | Expanded or passed-through 32-bit instruction |
| outIllegal | output | 1 | Reserved or unsupported compressed encoding |

## Verification
The main function is tried with four kinds of input:
- **32-bit words with random upper bits.** These separate pass-through from expansion, and show that a 16-bit word's upper half never leaks into the result.
- **Add-immediate words at the extremes.** The immediate is set to +31, -32 and -1, which exposes wrong sign extension or swapped immediate bits.
- **Stack loads with single offset bits set and with the full offset.** These expose any misplaced offset field.
- **Each of the four arithmetic operations with distinct register fields.** These tell apart the operation selection and the x8..x15 mapping.

Reserved cases are set right next to their legal neighbours: rd = 0, zero immediate, arithmetic with bit 12 set, and low bits 00. A long random run then mixes all of these classes with idle cycles, so that the hold behaviour is compared on every clock.

// File: rtl/cexp_pkg.sv
package cexp_pkg;
  localparam int ILEN        = 32;
  localparam int HALF        = 16;
  localparam int REG_BITS    = 5;
  localparam int CREG_BITS   = 3;
  localparam int CREG_OFFSET = 8;
  localparam int SP_REG      = 2;
  localparam int IMM_BITS    = 12;

  localparam logic [6:0] OPC_OPIMM = 7'b0010011;
  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_OP    = 7'b0110011;

  typedef enum logic [1:0] {
    AR_SUB = 2'b00,
    AR_XOR = 2'b01,
    AR_OR  = 2'b10,
    AR_AND = 2'b11
  } arithOp_e;

  typedef struct packed {
    logic full;      // 32-bit instruction, pass through
    logic selAddi;   // legal compressed add-immediate
    logic selLwsp;   // legal compressed stack load
    logic selArith;  // legal compressed register arithmetic
    logic bad;       // reserved or unsupported 16-bit encoding
  } ctrlStrobes_t;
endpackage

// File: rtl/cexp_ctrl.sv
module cexp_ctrl
  import cexp_pkg::*;
(
  input  logic [HALF-1:0] half,
  output ctrlStrobes_t    strobes,
  output arithOp_e        arithOp
);
  logic [1:0]          quad;
  logic [2:0]          funct3;
  logic [REG_BITS-1:0] rdField;
  logic                immZero;

  assign quad    = half[1:0];
  assign funct3  = half[15:13];
  assign rdField = half[11:7];
  assign immZero = (half[12] == 1'b0) && (half[6:2] == 5'd0);
  assign arithOp = arithOp_e'(half[6:5]);

  always_comb begin
    strobes = '0;
    if (quad == 2'b11) begin
      strobes.full = 1'b1;
    end else begin
      unique case ({funct3, quad})
        5'b000_01: begin
          if (rdField != '0 && !immZero) strobes.selAddi = 1'b1;
          else                           strobes.bad     = 1'b1;
        end
        5'b010_10: begin
          if (rdField != '0) strobes.selLwsp = 1'b1;
          else               strobes.bad     = 1'b1;
        end
        5'b100_01: begin
          if (half[12:10] == 3'b011) strobes.selArith = 1'b1;
          else                       strobes.bad      = 1'b1;
        end
        default: strobes.bad = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/cexp_datapath.sv
module cexp_datapath
  import cexp_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [ILEN-1:0] word,
  input  ctrlStrobes_t    strobes,
  input  arithOp_e        arithOp,
  output logic            outValid,
  output logic            outLen16,
  output logic [ILEN-1:0] outInstr,
  output logic            outIllegal
);
  function automatic logic [REG_BITS-1:0] mapCreg(input logic [CREG_BITS-1:0] n);
    return REG_BITS'(CREG_OFFSET) + REG_BITS'(n);
  endfunction

  logic [IMM_BITS-1:0] addiImm;
  logic [IMM_BITS-1:0] lwspOff;
  logic [REG_BITS-1:0] rdFull;
  logic [REG_BITS-1:0] rdPrime;
  logic [REG_BITS-1:0] rs2Prime;
  logic [6:0]          arithF7;
  logic [2:0]          arithF3;
  logic [ILEN-1:0]     addiInstr;
  logic [ILEN-1:0]     lwspInstr;
  logic [ILEN-1:0]     arithInstr;
  logic [ILEN-1:0]     nextInstr;

  assign rdFull   = word[11:7];
  assign rdPrime  = mapCreg(word[9:7]);
  assign rs2Prime = mapCreg(word[4:2]);

  // sign-extended 6-bit immediate
  assign addiImm = {{(IMM_BITS-6){word[12]}}, word[12], word[6:2]};
  // zero-extended, word-scaled offset
  assign lwspOff = {{(IMM_BITS-8){1'b0}}, word[3:2], word[12], word[6:4], 2'b00};

  always_comb begin
    arithF7 = 7'b0000000;
    unique case (arithOp)
      AR_SUB: begin arithF3 = 3'b000; arithF7 = 7'b0100000; end
      AR_XOR: arithF3 = 3'b100;
      AR_OR:  arithF3 = 3'b110;
      AR_AND: arithF3 = 3'b111;
      default: arithF3 = 3'b000;
    endcase
  end

  assign addiInstr  = {addiImm, rdFull, 3'b000, rdFull, OPC_OPIMM};
  assign lwspInstr  = {lwspOff, REG_BITS'(SP_REG), 3'b010, rdFull, OPC_LOAD};
  assign arithInstr = {arithF7, rs2Prime, rdPrime, arithF3, rdPrime, OPC_OP};

  always_comb begin
    nextInstr = '0;
    if (strobes.full)     nextInstr = word;
    if (strobes.selAddi)  nextInstr = addiInstr;
    if (strobes.selLwsp)  nextInstr = lwspInstr;
    if (strobes.selArith) nextInstr = arithInstr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outLen16   <= 1'b0;
      outInstr   <= '0;
      outIllegal <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outLen16   <= !strobes.full;
        outInstr   <= nextInstr;
        outIllegal <= strobes.bad;
      end
    end
  end
endmodule

// File: rtl/cexp_decoder.sv
module cexp_decoder
  import cexp_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [ILEN-1:0] fetchWord,
  output logic            outValid,
  output logic            outLen16,
  output logic [ILEN-1:0] outInstr,
  output logic            outIllegal
);
  ctrlStrobes_t strobes;
  arithOp_e     arithOp;

  cexp_ctrl u_ctrl (
    .half    (fetchWord[HALF-1:0]),
    .strobes (strobes),
    .arithOp (arithOp)
  );

  cexp_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .word       (fetchWord),
    .strobes    (strobes),
    .arithOp    (arithOp),
    .outValid   (outValid),
    .outLen16   (outLen16),
    .outInstr   (outInstr),
    .outIllegal (outIllegal)
  );
endmodule

// File: rtl/cexp_checker.sv
module cexp_checker
  import cexp_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            inValid,
  input logic [ILEN-1:0] fetchWord,
  input logic            outValid,
  input logic            outLen16,
  input logic [ILEN-1:0] outInstr,
  input logic            outIllegal
);
  // R9
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R9
  valid_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outInstr) && $stable(outIllegal) && $stable(outLen16)));
  // R1
  len_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (outLen16 == ($past(fetchWord[1:0]) != 2'b11)));
  // R2
  pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && fetchWord[1:0] == 2'b11) |=> (outInstr == $past(fetchWord) && !outIllegal));
  // R4
  addi_rsv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && fetchWord[15:13] == 3'b000 && fetchWord[1:0] == 2'b01 &&
     (fetchWord[11:7] == 5'd0 || (fetchWord[12] == 1'b0 && fetchWord[6:2] == 5'd0)))
    |=> outIllegal);
  // R6
  lwsp_rsv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && fetchWord[15:13] == 3'b010 && fetchWord[1:0] == 2'b10 &&
     fetchWord[11:7] == 5'd0) |=> outIllegal);
  // R8
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outIllegal) |-> (outInstr == '0 && outLen16));
  // R10
  always_comb begin
    if (!rstN) begin
      reset_state_chk: assert (!outValid && !outIllegal && outInstr == '0 && !outLen16);
    end
  end
endmodule

bind cexp_decoder cexp_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .fetchWord  (fetchWord),
  .outValid   (outValid),
  .outLen16   (outLen16),
  .outInstr   (outInstr),
  .outIllegal (outIllegal)
);

// File: tb/cexp_decoder_tb.sv
module cexp_decoder_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] fetchWord = '0;
  logic        outValid;
  logic        outLen16;
  logic [31:0] outInstr;
  logic        outIllegal;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // expected state of the registered outputs
  logic        expValid = 1'b0;
  logic        expLen16 = 1'b0;
  logic [31:0] expInstr = '0;
  logic        expIll = 1'b0;
  string       expTag = "R10";

  always #5 clk = ~clk;

  cexp_decoder u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .fetchWord(fetchWord),
    .outValid(outValid), .outLen16(outLen16), .outInstr(outInstr), .outIllegal(outIllegal)
  );

  // encoders for test words
  function automatic logic [31:0] encAddi(input logic [4:0] rd, input int imm, input logic [15:0] hi);
    logic [5:0] im = 6'(imm);
    return {hi, 3'b000, im[5], rd, im[4:0], 2'b01};
  endfunction
  function automatic logic [31:0] encLwsp(input logic [4:0] rd, input int off, input logic [15:0] hi);
    logic [7:0] o = 8'(off);
    return {hi, 3'b010, o[5], rd, o[4:2], o[7:6], 2'b10};
  endfunction
  function automatic logic [31:0] encArith(input logic [2:0] rdp, input logic [1:0] op,
                                           input logic [2:0] rs2p, input logic [15:0] hi);
    return {hi, 6'b100011, rdp, op, rs2p, 2'b01};
  endfunction

  // behavioural reference model built from the requirements
  task automatic refModel(input logic [31:0] w, output logic len16, output logic [31:0] ins,
                          output logic ill, output string tag);
    int imm;
    int off;
    logic [31:0] immv;
    logic [4:0] rd;
    logic [4:0] a;
    logic [4:0] b;
    len16 = (w[1:0] != 2'b11);
    ins = 32'h0;
    ill = 1'b1;
    tag = "R8";
    rd = w[11:7];
    if (!len16) begin
      ins = w; ill = 1'b0; tag = "R2";
    end else if (w[1:0] == 2'b01 && w[15:13] == 3'b000) begin
      imm = int'(w[6:2]) - (w[12] ? 32 : 0);
      if (rd == 0 || imm == 0) tag = "R4";
      else begin
        immv = 32'(imm);
        ins = (immv << 20) | (32'(rd) << 15) | (32'(rd) << 7) | 32'h13;
        ill = 1'b0; tag = "R3";
      end
    end else if (w[1:0] == 2'b10 && w[15:13] == 3'b010) begin
      if (rd == 0) tag = "R6";
      else begin
        off = int'(w[6:4]) * 4 + int'(w[12]) * 32 + int'(w[3:2]) * 64;
        ins = (32'(off) << 20) | (32'd2 << 15) | (32'd2 << 12) | (32'(rd) << 7) | 32'h03;
        ill = 1'b0; tag = "R5";
      end
    end else if (w[1:0] == 2'b01 && w[15:10] == 6'b100011) begin
      a = 5'(8 + int'(w[9:7]));
      b = 5'(8 + int'(w[4:2]));
      ins = (32'(b) << 20) | (32'(a) << 15) | (32'(a) << 7) | 32'h33;
      case (w[6:5])
        2'b00: ins = ins | (32'h20 << 25);
        2'b01: ins = ins | (32'd4 << 12);
        2'b10: ins = ins | (32'd6 << 12);
        default: ins = ins | (32'd7 << 12);
      endcase
      ill = 1'b0; tag = "R7";
    end
  endtask

  task automatic compareAll();
    checks++;
    if (outValid !== expValid) begin
      failures++;
      $display("FAIL R9 outValid actual=%0b expected=%0b", outValid, expValid);
    end
    checks++;
    if (outLen16 !== expLen16) begin
      failures++;
      $display("FAIL R1 outLen16 actual=%0b expected=%0b", outLen16, expLen16);
    end
    checks++;
    if (outInstr !== expInstr) begin
      failures++;
      $display("FAIL %s outInstr actual=%08h expected=%08h", expTag, outInstr, expInstr);
    end
    checks++;
    if (outIllegal !== expIll) begin
      failures++;
      $display("FAIL %s outIllegal actual=%0b expected=%0b", expTag, outIllegal, expIll);
    end
  endtask

  // drive at negedge, check at following negedge (one register stage)
  task automatic step(input logic v, input logic [31:0] w);
    logic l; logic [31:0] i; logic il; string t;
    inValid = v;
    fetchWord = w;
    @(posedge clk);
    expValid = v;
    if (v) begin
      refModel(w, l, i, il, t);
      expLen16 = l; expInstr = i; expIll = il; expTag = t;
    end else begin
      expTag = "R9";
    end
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    compareAll();
    rstN = 1'b1;
    @(negedge clk);

    // R2 pass-through
    step(1'b1, 32'hDEAD_BEE3);
    step(1'b1, 32'h0000_0013);
    // R3 add-immediate extremes
    step(1'b1, encAddi(5'd10, 31, 16'hFFFF));
    step(1'b1, encAddi(5'd1, -32, 16'h1234));
    step(1'b1, encAddi(5'd31, -1, 16'h0000));
    // R4 reserved add-immediate
    step(1'b1, encAddi(5'd0, 5, 16'h5555));
    step(1'b1, encAddi(5'd7, 0, 16'hAAAA));
    // R9 idle cycles hold outputs
    step(1'b0, 32'hFFFF_FFFF);
    step(1'b0, 32'h0000_0001);
    // R5 stack loads, single offset bits and full offset
    step(1'b1, encLwsp(5'd5, 4, 16'hFFFF));
    step(1'b1, encLwsp(5'd5, 32, 16'h0));
    step(1'b1, encLwsp(5'd5, 64, 16'h0));
    step(1'b1, encLwsp(5'd31, 252, 16'h0F0F));
    // R6 reserved stack load
    step(1'b1, encLwsp(5'd0, 8, 16'h0));
    // R7 each arithmetic op and register mapping
    step(1'b1, encArith(3'b100, 2'b00, 3'b011, 16'hFFFF));
    step(1'b1, encArith(3'b000, 2'b01, 3'b111, 16'h0));
    step(1'b1, encArith(3'b111, 2'b10, 3'b001, 16'h0));
    step(1'b1, encArith(3'b010, 2'b11, 3'b101, 16'h0));
    // R8 unsupported encodings
    step(1'b1, {16'h0, 16'b100111_010_00_011_01});
    step(1'b1, 32'h0000_4000);
    step(1'b1, 32'h0000_0000);
    step(1'b1, 32'h0000_8002);

    // random mix of every class, with idle cycles
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] r;
      int kind;
      r = $urandom;
      kind = int'($urandom % 6);
      case (kind)
        0: r = encAddi(r[11:7], int'($urandom % 64) - 32, r[31:16]);
        1: r = encLwsp(r[11:7], int'($urandom % 64) * 4, r[31:16]);
        2: r = encArith(r[9:7], r[6:5], r[4:2], r[31:16]);
        3: r = r | 32'h3;
        default: ;
      endcase
      step(($urandom % 5) != 0, r);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule